// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable model of a small synchronous SRAM with a one-cycle registered read path and a two-bit burst address counter. A new address is accepted through one of two active-low address strobes. The processor strobe takes priority over the controller strobe, and it is itself gated by the first chip select. At each load the three chip selects decide whether the device becomes selected or deselected. After a load, the device can step through the four words of an aligned block with an advance input, one word per clock. It does not need a fresh address for each word.

Each word holds four byte lanes, and each lane carries its own parity bit. A write can cover the whole word through a global write input. It can also cover only some lanes, using a lane-write enable together with per-lane selects. Data uses split input and output ports. An output-enable flag takes the place of tristate pins. The flag is held low during write data phases, while the device is deselected, and on the first data beat after the device leaves the deselected state.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset the device is deselected, and `rd_oe_o` stays low even with `out_en_n` low.
- R2: A load selects the device only when `cs_a_n`=0, `cs_b_i`=1 and `cs_c_n`=0. A load that fails this check deselects the device, and no write and no output take place until the next load that passes.
- R3: When both strobes are low in the same cycle and `cs_a_n` is low, only the processor strobe acts. The cycle is a read, and the write inputs have no effect on the array.
- R4: The processor strobe is ignored when `cs_a_n` is high. With the controller strobe high, that cycle behaves as a non-load cycle, and the current selection and address are kept.
- R5: A cycle that loads through the processor strobe is always a read, whatever the write inputs say. Writes are possible on the cycles that follow it.
- R6: Each load sets the burst counter from `addr_i[1:0]` and takes the upper address bits from `addr_i`. On a non-load cycle with `burst_adv_n` low, the counter steps by one modulo 4 and the upper bits are held, so the access wraps within the aligned 4-word block.
- R7: On a non-load cycle with `burst_adv_n` high, the access stays at the same address.
- R8: With `all_wr_n` low, all four lanes of the word are written, including each parity bit. This holds whatever `lane_wr_en_n` and `lane_sel_n` are.
- R9: With `all_wr_n` high and `lane_wr_en_n` low, lane k (data bits [8k+7:8k] and parity bit k) is written only if `lane_sel_n[k]` is low. With `lane_wr_en_n` high, or with all selects high, the cycle is a read.
- R10: A read accesses the word at the address in effect at a clock edge. Its data and parity appear on `rdata_o`/`rpar_o` in the cycle after that edge.
- R11: `out_en_n` high forces `rd_oe_o` low without waiting for a clock edge.
- R12: In the cycle after a write edge, `rd_oe_o` is low.
- R13: After a load that moves the device from deselected to selected, `rd_oe_o` is low in the cycle after that load edge. Later read beats show data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Word address, sampled on loads |
| cs_a_n | input | 1 | Chip select A, active low; also gates the processor strobe |
| cs_b_i | input | 1 | Chip select B, active high |
| cs_c_n | input | 1 | Chip select C, active low |
| proc_strb_n | input | 1 | Processor address strobe, active low, higher priority |
| ctrl_strb_n | input | 1 | Controller address strobe, active low |
| burst_adv_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Global write of all lanes, active low |
| lane_wr_en_n | input | 1 | Lane-write enable, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low |
| out_en_n | input | 1 | Output enable, active low, asynchronous |
| wdata_i | input | 32 | Write data, lane k in bits [8k+7:8k] |
| wpar_i | input | 4 | Write parity, bit k for lane k |
| rdata_o | output | 32 | Registered read data |
| rpar_o | output | 4 | Registered read parity |
| rd_oe_o | output | 1 | Read data drive flag |

## Verification
The bench drives cycles in which both strobes collide while a write is requested. A design that let the controller strobe win would write the word, and a later read would return the wrong data. It blocks the processor strobe with the first chip select high. A design that loaded anyway would jump to address 0 instead of continuing the current burst. It runs the counter past the top of an aligned block, where a design that carried into the upper bits would read the next block. It mixes a global write with lane selects that name only some lanes, which would catch a design that honoured the selects. It also checks the first beat after deselect and after writes, where a design without the masks would raise the output flag.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

   typedef enum logic [1:0] {
      SBS_IDLE  = 2'd0,
      SBS_READ  = 2'd1,
      SBS_WRITE = 2'd2
   } sbs_op_e;

   // width of one stored lane: data byte plus its parity bit
   function automatic int lane_bits(input int lane_w);
      return lane_w + 1;
   endfunction

endpackage

// File: rtl/sbs_strobe_dec.sv
module sbs_strobe_dec (
   input  logic proc_strb_n,
   input  logic ctrl_strb_n,
   input  logic cs_a_n,
   input  logic cs_b_i,
   input  logic cs_c_n,
   output logic load_o,
   output logic proc_load_o,
   output logic cs_ok_o
);
   always_comb begin
      // processor strobe only counts when chip select A is active
      proc_load_o = ~proc_strb_n & ~cs_a_n;
      // controller strobe loads whenever the processor strobe did not
      load_o      = proc_load_o | ~ctrl_strb_n;
      cs_ok_o     = ~cs_a_n & cs_b_i & ~cs_c_n;
   end
endmodule

// File: rtl/sbs_burst_addr.sv
module sbs_burst_addr #(
   parameter int ADDR_W = 4,
   parameter int CNT_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              step_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] eff_addr_o,
   output logic [CNT_W-1:0]  cnt_o
);
   localparam int HI_W = ADDR_W - CNT_W;

   logic [HI_W-1:0]  hi_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic [HI_W-1:0]  hi_nxt;

   always_comb begin
      if (load_i) begin
         cnt_nxt = addr_i[CNT_W-1:0];
         hi_nxt  = addr_i[ADDR_W-1:CNT_W];
      end else begin
         // linear order, wraps inside the aligned block
         cnt_nxt = step_i ? cnt_q + 1'b1 : cnt_q;
         hi_nxt  = hi_q;
      end
      eff_addr_o = {hi_nxt, cnt_nxt};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q  <= '0;
         cnt_q <= '0;
      end else begin
         hi_q  <= hi_nxt;
         cnt_q <= cnt_nxt;
      end
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/sbs_lane_array.sv
module sbs_lane_array #(
   parameter int DEPTH       = 16,
   parameter int LANES       = 4,
   parameter int LANE_W      = 8,
   parameter bit ARRAY_RESET = 1'b1
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [LANES-1:0]                      we_i,
   input  logic [$clog2(DEPTH)-1:0]              addr_i,
   input  logic [LANES*sbs_pkg::lane_bits(LANE_W)-1:0] wword_i,
   output logic [LANES*sbs_pkg::lane_bits(LANE_W)-1:0] rword_o
);
   localparam int LB = sbs_pkg::lane_bits(LANE_W);

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [LB-1:0] mem [DEPTH];

      if (ARRAY_RESET) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we_i[k]) begin
               mem[addr_i] <= wword_i[k*LB +: LB];
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (we_i[k]) mem[addr_i] <= wword_i[k*LB +: LB];
         end
      end

      assign rword_o[k*LB +: LB] = mem[addr_i];
   end
endmodule

// File: rtl/sbs_out_stage.sv
module sbs_out_stage #(
   parameter int WORD_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              out_en_n,
   output logic [WORD_W-1:0] word_o,
   output logic              oe_o
);
   logic              vld_q;
   logic [WORD_W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         word_q <= '0;
      end else begin
         vld_q <= fire_i;
         if (fire_i) word_q <= word_i;
      end
   end

   assign word_o = word_q;
   assign oe_o   = vld_q & ~out_en_n;
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
   parameter int DEPTH       = 16,
   parameter int LANES       = 4,
   parameter int LANE_W      = 8,
   parameter int CNT_W       = 2,
   parameter bit ARRAY_RESET = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [$clog2(DEPTH)-1:0]  addr_i,
   input  logic                      cs_a_n,
   input  logic                      cs_b_i,
   input  logic                      cs_c_n,
   input  logic                      proc_strb_n,
   input  logic                      ctrl_strb_n,
   input  logic                      burst_adv_n,
   input  logic                      all_wr_n,
   input  logic                      lane_wr_en_n,
   input  logic [LANES-1:0]          lane_sel_n,
   input  logic                      out_en_n,
   input  logic [LANES*LANE_W-1:0]   wdata_i,
   input  logic [LANES-1:0]          wpar_i,
   output logic [LANES*LANE_W-1:0]   rdata_o,
   output logic [LANES-1:0]          rpar_o,
   output logic                      rd_oe_o
);
   import sbs_pkg::*;

   localparam int ADDR_W = $clog2(DEPTH);
   localparam int LB     = lane_bits(LANE_W);
   localparam int WORD_W = LANES * LB;

   if ((1 << ADDR_W) != DEPTH) begin : g_chk_depth
      $error("DEPTH must be a power of two");
   end
   if (CNT_W < 1 || ADDR_W <= CNT_W) begin : g_chk_cnt
      $error("CNT_W must be at least 1 and below the address width");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_chk_lane
      $error("LANES and LANE_W must be positive");
   end

   logic              load;
   logic              proc_load;
   logic              cs_ok;
   logic              sel_q;
   logic              sel_nxt;
   logic              emerge;
   logic              step;
   logic [ADDR_W-1:0] eff_addr;
   logic [CNT_W-1:0]  cnt_lo;
   logic              wr_req;
   sbs_op_e           op;
   logic [LANES-1:0]  lane_we;
   logic [WORD_W-1:0] wword;
   logic [WORD_W-1:0] rword;
   logic [WORD_W-1:0] rword_q;
   logic              fire;

   sbs_strobe_dec u_dec (
      .proc_strb_n (proc_strb_n),
      .ctrl_strb_n (ctrl_strb_n),
      .cs_a_n      (cs_a_n),
      .cs_b_i      (cs_b_i),
      .cs_c_n      (cs_c_n),
      .load_o      (load),
      .proc_load_o (proc_load),
      .cs_ok_o     (cs_ok)
   );

   // selection state changes only on loads
   always_comb begin
      sel_nxt = load ? cs_ok : sel_q;
      emerge  = load & cs_ok & ~sel_q;
      step    = sel_q & ~burst_adv_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= 1'b0;
      else        sel_q <= sel_nxt;
   end

   sbs_burst_addr #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W)
   ) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .step_i     (step),
      .addr_i     (addr_i),
      .eff_addr_o (eff_addr),
      .cnt_o      (cnt_lo)
   );

   // cycle operation
   always_comb begin
      wr_req = ~all_wr_n | (~lane_wr_en_n & ~(&lane_sel_n));
      if (!sel_nxt)                 op = SBS_IDLE;
      else if (wr_req && !proc_load) op = SBS_WRITE;
      else                          op = SBS_READ;
      fire = (op == SBS_READ) & ~emerge;
   end

   for (genvar k = 0; k < LANES; k++) begin : g_pack
      assign lane_we[k] = (op == SBS_WRITE) &
                          (~all_wr_n | (~lane_wr_en_n & ~lane_sel_n[k]));
      assign wword[k*LB +: LB]       = {wpar_i[k], wdata_i[k*LANE_W +: LANE_W]};
      assign rdata_o[k*LANE_W +: LANE_W] = rword_q[k*LB +: LANE_W];
      assign rpar_o[k]                = rword_q[k*LB + LANE_W];
   end

   sbs_lane_array #(
      .DEPTH       (DEPTH),
      .LANES       (LANES),
      .LANE_W      (LANE_W),
      .ARRAY_RESET (ARRAY_RESET)
   ) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (lane_we),
      .addr_i  (eff_addr),
      .wword_i (wword),
      .rword_o (rword)
   );

   sbs_out_stage #(
      .WORD_W (WORD_W)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire_i   (fire),
      .word_i   (rword),
      .out_en_n (out_en_n),
      .word_o   (rword_q),
      .oe_o     (rd_oe_o)
   );
endmodule

// File: rtl/sbs_chk.sv
module sbs_chk #(
   parameter int CNT_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             proc_strb_n,
   input logic             ctrl_strb_n,
   input logic             cs_a_n,
   input logic             cs_b_i,
   input logic             cs_c_n,
   input logic             burst_adv_n,
   input logic             out_en_n,
   input logic             rd_oe_o,
   input logic             load,
   input logic             sel_q,
   input logic             any_we,
   input logic [CNT_W-1:0] cnt
);
   // R11
   oe_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_en_n |-> !rd_oe_o);

   // R3
   collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!proc_strb_n && !cs_a_n && !ctrl_strb_n) |-> !any_we);

   // R2
   desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !(!cs_a_n && cs_b_i && !cs_c_n)) |=> !sel_q);

   // R2
   desel_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_q && !load) |-> !any_we);

   // R12
   wr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_we |=> !rd_oe_o);

   // R13
   emerge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !cs_a_n && cs_b_i && !cs_c_n && !sel_q) |=> !rd_oe_o);

   // R6
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q && !load && !burst_adv_n && (cnt == '1)) |=> (cnt == '0));

   // R4
   pblock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!proc_strb_n && cs_a_n && ctrl_strb_n) |=> (sel_q == $past(sel_q)));
endmodule

bind sync_burst_sram sbs_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .proc_strb_n (proc_strb_n),
   .ctrl_strb_n (ctrl_strb_n),
   .cs_a_n      (cs_a_n),
   .cs_b_i      (cs_b_i),
   .cs_c_n      (cs_c_n),
   .burst_adv_n (burst_adv_n),
   .out_en_n    (out_en_n),
   .rd_oe_o     (rd_oe_o),
   .load        (load),
   .sel_q       (sel_q),
   .any_we      (|lane_we),
   .cnt         (cnt_lo)
);

// File: tb/sync_burst_sram_bench.sv
`timescale 1ns/1ps
module sync_burst_sram_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  addr_i = '0;
   logic        cs_a_n = 1'b1, cs_b_i = 1'b0, cs_c_n = 1'b1;
   logic        proc_strb_n = 1'b1, ctrl_strb_n = 1'b1, burst_adv_n = 1'b1;
   logic        all_wr_n = 1'b1, lane_wr_en_n = 1'b1;
   logic [3:0]  lane_sel_n = 4'hF;
   logic        out_en_n = 1'b0;
   logic [31:0] wdata_i = '0;
   logic [3:0]  wpar_i = '0;
   logic [31:0] rdata_o;
   logic [3:0]  rpar_o;
   logic        rd_oe_o;

   always #4 clk = ~clk;

   sync_burst_sram u_sync_burst_sram (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
      .cs_a_n(cs_a_n), .cs_b_i(cs_b_i), .cs_c_n(cs_c_n),
      .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n),
      .burst_adv_n(burst_adv_n), .all_wr_n(all_wr_n),
      .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
      .out_en_n(out_en_n), .wdata_i(wdata_i), .wpar_i(wpar_i),
      .rdata_o(rdata_o), .rpar_o(rpar_o), .rd_oe_o(rd_oe_o)
   );

   typedef struct {
      logic        oe;
      logic [31:0] d;
      logic [3:0]  p;
      string       tag;
   } exp_t;

   exp_t sbq[$];
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   // reference state
   bit          m_sel = 1'b0;
   logic [1:0]  m_hi = '0;
   logic [1:0]  m_cnt = '0;
   logic [31:0] m_dat [16];
   logic [3:0]  m_par [16];

   localparam logic [2:0] CS_OK  = 3'b010; // {cs_a_n, cs_b_i, cs_c_n}
   localparam logic [2:0] CS_A1  = 3'b110;
   localparam logic [2:0] CS_B0  = 3'b000;
   localparam logic [1:0] ST_P   = 2'b01;  // {proc_strb_n, ctrl_strb_n}
   localparam logic [1:0] ST_C   = 2'b10;
   localparam logic [1:0] ST_ALL = 2'b00;
   localparam logic [1:0] ST_NO  = 2'b11;

   task automatic cyc(input logic [3:0] a, input logic [2:0] cs,
                      input logic [1:0] st, input logic adv,
                      input logic gw, input logic bwe, input logic [3:0] bw,
                      input logic oe, input logic [31:0] d, input logic [3:0] p,
                      input string tag);
      logic       pl, ld, ok, emg, wr;
      logic [1:0] lo;
      logic [3:0] ea;
      exp_t       e;
      @(negedge clk);
      addr_i = a; {cs_a_n, cs_b_i, cs_c_n} = cs;
      {proc_strb_n, ctrl_strb_n} = st; burst_adv_n = adv;
      all_wr_n = gw; lane_wr_en_n = bwe; lane_sel_n = bw;
      out_en_n = oe; wdata_i = d; wpar_i = p;
      pl  = !st[1] && !cs[2];
      ld  = pl || !st[0];
      ok  = (cs == CS_OK);
      emg = 1'b0;
      if (ld) begin
         emg   = ok && !m_sel;
         m_sel = ok;
         m_hi  = a[3:2];
         lo    = a[1:0];
      end else begin
         lo = (m_sel && !adv) ? m_cnt + 2'd1 : m_cnt;
      end
      m_cnt = lo;
      ea = {m_hi, lo};
      wr = m_sel && !pl && (!gw || (!bwe && bw != 4'hF));
      if (wr) begin
         for (int k = 0; k < 4; k++) begin
            if (!gw || (!bwe && !bw[k])) begin
               m_dat[ea][k*8 +: 8] = d[k*8 +: 8];
               m_par[ea][k]        = p[k];
            end
         end
      end
      e.oe  = m_sel && !wr && !emg && !oe;
      e.d   = m_dat[ea];
      e.p   = m_par[ea];
      e.tag = tag;
      sbq.push_back(e);
   endtask

   // scoreboard monitor
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #2;
         if (sbq.size() > 0) begin
            e = sbq.pop_front();
            n_chk++;
            if (rd_oe_o !== e.oe) begin
               n_fail++;
               $display("FAIL %s: rd_oe_o actual %b expected %b", e.tag, rd_oe_o, e.oe);
            end else if (e.oe && ({rpar_o, rdata_o} !== {e.p, e.d})) begin
               n_fail++;
               $display("FAIL %s: word actual %h_%h expected %h_%h",
                        e.tag, rpar_o, rdata_o, e.p, e.d);
            end
         end
      end
   end

   initial begin
      #1600000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) begin m_dat[i] = '0; m_par[i] = '0; end
      repeat (3) @(posedge clk);
      #2;
      n_chk++; // R1 during reset
      if (rd_oe_o !== 1'b0) begin n_fail++; $display("FAIL R1: rd_oe_o actual %b expected 0", rd_oe_o); end
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #2;
      n_chk++; // R1 after reset, no load yet
      if (rd_oe_o !== 1'b0) begin n_fail++; $display("FAIL R1: rd_oe_o actual %b expected 0", rd_oe_o); end

      // burst write of block 4..7, first beat on emerging edge
      cyc(4'd4, CS_OK, ST_C, 1, 0, 1, 4'hF, 0, 32'hA1A2A3A4, 4'h5, "R8");
      cyc(4'd0, CS_OK, ST_NO, 0, 0, 1, 4'hF, 0, 32'hB1B2B3B4, 4'hA, "R6");
      cyc(4'd0, CS_OK, ST_NO, 0, 0, 1, 4'hF, 0, 32'hC1C2C3C4, 4'h3, "R6");
      cyc(4'd0, CS_OK, ST_NO, 0, 0, 1, 4'hF, 0, 32'hD1D2D3D4, 4'hC, "R12");
      cyc(4'd0, CS_OK, ST_NO, 0, 1, 1, 4'hF, 0, 32'h0, 4'h0, "R6");   // wrap to 4
      cyc(4'd0, CS_OK, ST_NO, 0, 1, 1, 4'hF, 0, 32'h0, 4'h0, "R10");  // 5
      cyc(4'd0, CS_OK, ST_NO, 1, 1, 1, 4'hF, 0, 32'h0, 4'h0, "R7");   // hold 5
      // lane write, lanes 0 and 2
      cyc(4'd6, CS_OK, ST_C, 1, 1, 0, 4'b1010, 0, 32'h11223344, 4'hF, "R9");
      cyc(4'd6, CS_OK, ST_C, 1, 1, 1, 4'hF, 0, 32'h0, 4'h0, "R9");
      // selects without enable: read
      cyc(4'd0, CS_OK, ST_NO, 0, 1, 1, 4'h0, 0, 32'hFFFFFFFF, 4'hF, "R9");
      cyc(4'd0, CS_OK, ST_NO, 1, 1, 1, 4'hF, 0, 32'h0, 4'h0, "R9");
      cyc(4'd0, CS_OK, ST_NO, 1, 1, 1, 4'hF, 1, 32'h0, 4'h0, "R11");
      // strobe collision with global write
      cyc(4'd8, CS_OK, ST_ALL, 1, 0, 1, 4'hF, 0, 32'hDEADBEEF, 4'hF, "R3");
      cyc(4'd0, CS_OK, ST_NO, 1, 1, 1, 4'hF, 0, 32'h0, 4'h0, "R3");
      // processor load with write request, then write beat
      cyc(4'd9, CS_OK, ST_P, 1, 0, 1, 4'hF, 0, 32'h99999999, 4'h9, "R5");
      cyc(4'd0, CS_OK, ST_NO, 1, 0, 1, 4'hF, 0, 32'h12345678, 4'h6, "R12");
      cyc(4'd0, CS_OK, ST_NO, 1, 1, 1, 4'hF, 0, 32'h0, 4'h0, "R5");
      // processor strobe blocked by chip select A
      cyc(4'd0, CS_A1, ST_P, 1, 1, 1, 4'hF, 0, 32'h0, 4'h0, "R4");
      // controller load with failing selects: deselect
      cyc(4'd0, CS_A1, ST_ALL, 1, 1, 1, 4'hF, 0, 32'h0, 4'h0, "R2");
      cyc(4'd4, CS_OK, ST_NO, 0, 0, 1, 4'hF, 0, 32'h77777777, 4'h7, "R2");
      cyc(4'd4, CS_B0, ST_C, 1, 0, 1, 4'hF, 0, 32'h66666666, 4'h6, "R2");
      // emerging read, first beat masked
      cyc(4'd4, CS_OK, ST_C, 1, 1, 1, 4'hF, 0, 32'h0, 4'h0, "R13");
      cyc(4'd0, CS_OK, ST_NO, 1, 1, 1, 4'hF, 0, 32'h0, 4'h0, "R13");
      cyc(4'd9, CS_OK, ST_C, 1, 1, 1, 4'hF, 0, 32'h0, 4'h0, "R5");
      // global write overrides lane selects
      cyc(4'd12, CS_OK, ST_C, 1, 0, 0, 4'b1110, 0, 32'hCAFEF00D, 4'hB, "R8");
      cyc(4'd0, CS_OK, ST_NO, 1, 1, 1, 4'hF, 0, 32'h0, 4'h0, "R8");
      // processor load at top of block, wrap keeps upper bits
      cyc(4'd14, CS_OK, ST_P, 1, 1, 1, 4'hF, 0, 32'h0, 4'h0, "R6");
      cyc(4'd0, CS_OK, ST_NO, 0, 1, 1, 4'hF, 0, 32'h0, 4'h0, "R6");
      cyc(4'd0, CS_OK, ST_NO, 0, 1, 1, 4'hF, 0, 32'h0, 4'h0, "R6");
      cyc(4'd0, CS_OK, ST_NO, 0, 1, 1, 4'hF, 0, 32'h0, 4'h0, "R10");

      @(negedge clk);
      {proc_strb_n, ctrl_strb_n} = ST_NO;
      repeat (3) @(posedge clk);
      #3;
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule